// File: doc/BRIEF.md
# BERT Status and Interrupt Latch

This block collects the status of a bit-error-rate tester inside one line interface port and turns it into an interrupt. The pattern checker supplies a live out-of-sync level, a one-cycle pulse for every bit error, and a strobe for every received bit. The block keeps running bit and error counters. When a performance-monitoring update is requested, it copies both counters into holding registers and then raises an update-complete flag. The request comes either from a software control bit or from an external pin.

Software sees a live status word and a latched status word. Each bit of the latched word is set by an event and is cleared when software writes a 1 to it. Each latched bit has its own interrupt enable. The interrupt output also needs the port-level enable and the global enable, which are inputs to the block. A plain register port with a 7-bit byte offset covers one 128-byte port window. Reads are combinational and writes take effect at a clock edge.

Register offsets: 0x50 control (bit 0 software request, bit 1 request source: 0 software, 1 pin), 0x54 held bit count, 0x58 held error count, 0x5C live status, 0x5E latched status, 0x60 interrupt enables (bits 3..0 match latched bits 3..0). Unmapped offsets read as zero.

Top module: `bert_stat_irq`

## Requirements
- R1: After reset, every register reads 0, including offsets 0x50, 0x5C, 0x5E and 0x60, and irq is 0.
- R2: Live status at 0x5C has bit 3 = update complete, bit 1 = held error count nonzero and bit 0 = the out-of-sync input. Bit 2 and bits 15..4 read as 0.
- R3: When control bit 1 is 0, the request is control bit 0. When it is 1, the request is the reqPin input after two synchronizer flops, and control bit 0 has no effect.
- R4: A capture happens one clock after the synchronized request rises. It copies the running bit and error counts into 0x54 and 0x58 and restarts both running counts. An event in the capture cycle is counted in the new interval.
- R5: Update complete rises one clock after the capture and stays high while the request is high. It falls at once, without a clock edge, when the raw request (the control bit or the unsynchronized pin) goes low.
- R6: Live bit 1 is 1 exactly when the held error count is nonzero.
- R7: Latched bit 3 sets on a 0-to-1 change of update complete. Latched bit 1 sets on a 0-to-1 change of live bit 1.
- R8: Latched bit 2 sets on each errPulse. Latched bit 0 sets on any change of oosIn, in either direction.
- R9: Writing 0x5E clears each latched bit written with 1. Bits written with 0 keep their value. A set event in the same cycle as a clear wins.
- R10: irq is 1 exactly when some latched bit and its enable at 0x60 are both 1 and portEn and globalEn are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One received bit this cycle |
| errPulse | input | 1 | One bit error this cycle |
| oosIn | input | 1 | Checker out of sync |
| reqPin | input | 1 | External update request |
| portEn | input | 1 | Port-level status interrupt enable |
| globalEn | input | 1 | Global enable for this port |
| regAddr | input | 7 | Byte offset in port window |
| regWr | input | 1 | Write strobe |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
A register write lands at the clock edge where regWr is high. A software request therefore fills the holding registers one edge after the write, raises update complete one edge after that, and sets latched bit 3 on the edge after that. A pin request adds two synchronizer edges ahead of the capture. The bench reads each result just after the edge where it is due, and it also reads the cycle before, so an early or late result is caught. The forced-low path is checked half a cycle after the pin drops, with no clock edge in between. The interrupt gating is checked combinationally, right after its enables are applied.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  localparam int DW = 16;
  localparam int AW = 7;
  localparam int NLAT = 4;

  localparam logic [AW-1:0] OFF_CTRL  = 7'h50;
  localparam logic [AW-1:0] OFF_BHOLD = 7'h54;
  localparam logic [AW-1:0] OFF_EHOLD = 7'h58;
  localparam logic [AW-1:0] OFF_LIVE  = 7'h5C;
  localparam logic [AW-1:0] OFF_LAT   = 7'h5E;
  localparam logic [AW-1:0] OFF_IE    = 7'h60;

  typedef struct packed {
    logic capture;
    logic latClr;
  } bslStb_t;
endpackage

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
  import bsl_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqPin,
  input  logic [AW-1:0]   regAddr,
  input  logic            regWr,
  input  logic [DW-1:0]   regWdata,
  output bslStb_t         stb,
  output logic [DW-1:0]   ctrlWord,
  output logic [NLAT-1:0] ieMask,
  output logic            reqRaw,
  output logic            updDone
);
  logic swReq, modeSel;
  logic syncA, syncB, reqD1, capDly, doneReg;
  logic reqEff;

  assign reqEff = modeSel ? syncB : swReq;
  assign reqRaw = modeSel ? reqPin : swReq;

  always_comb begin
    stb.capture = reqEff & ~reqD1;
    stb.latClr  = regWr && (regAddr == OFF_LAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swReq   <= 1'b0;
      modeSel <= 1'b0;
      ieMask  <= '0;
    end else if (regWr) begin
      if (regAddr == OFF_CTRL) begin
        swReq   <= regWdata[0];
        modeSel <= regWdata[1];
      end
      if (regAddr == OFF_IE) ieMask <= regWdata[NLAT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      reqD1   <= 1'b0;
      capDly  <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      syncA   <= reqPin;
      syncB   <= syncA;
      reqD1   <= reqEff;
      capDly  <= stb.capture;
      doneReg <= reqRaw & (doneReg | capDly);
    end
  end

  // the raw request gates the flag directly, so it drops without a clock
  assign updDone  = doneReg & reqRaw;
  assign ctrlWord = {{(DW-2){1'b0}}, modeSel, swReq};
endmodule

// File: rtl/bsl_datapath.sv
module bsl_datapath
  import bsl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  bslStb_t         stb,
  input  logic            bitEn,
  input  logic            errPulse,
  input  logic            oosIn,
  input  logic            updDone,
  input  logic            portEn,
  input  logic            globalEn,
  input  logic [NLAT-1:0] ieMask,
  input  logic [DW-1:0]   ctrlWord,
  input  logic [AW-1:0]   regAddr,
  input  logic [DW-1:0]   regWdata,
  output logic [DW-1:0]   regRdata,
  output logic [DW-1:0]   liveStat,
  output logic [NLAT-1:0] latStat,
  output logic            irq
);
  logic [CNT_W-1:0] bitRun, errRun, bitHold, errHold;
  logic nzFlag, prevNz, prevDone, prevOos;
  logic [NLAT-1:0] setEv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitRun  <= '0;
      errRun  <= '0;
      bitHold <= '0;
      errHold <= '0;
    end else if (stb.capture) begin
      bitHold <= bitRun;
      errHold <= errRun;
      bitRun  <= CNT_W'(bitEn);
      errRun  <= CNT_W'(errPulse);
    end else begin
      bitRun  <= bitRun + CNT_W'(bitEn);
      errRun  <= errRun + CNT_W'(errPulse);
    end
  end

  assign nzFlag = |errHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevNz   <= 1'b0;
      prevDone <= 1'b0;
      prevOos  <= 1'b0;
    end else begin
      prevNz   <= nzFlag;
      prevDone <= updDone;
      prevOos  <= oosIn;
    end
  end

  assign setEv = {updDone & ~prevDone, errPulse, nzFlag & ~prevNz, oosIn ^ prevOos};

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rstN) latStat[i] <= 1'b0;
      else latStat[i] <= setEv[i] | (latStat[i] & ~(stb.latClr & regWdata[i]));
    end
  end

  assign liveStat = {{(DW-4){1'b0}}, updDone, 1'b0, nzFlag, oosIn};
  assign irq = (|(latStat & ieMask)) & portEn & globalEn;

  always_comb begin
    case (regAddr)
      OFF_CTRL:  regRdata = ctrlWord;
      OFF_BHOLD: regRdata = DW'(bitHold);
      OFF_EHOLD: regRdata = DW'(errHold);
      OFF_LIVE:  regRdata = liveStat;
      OFF_LAT:   regRdata = {{(DW-NLAT){1'b0}}, latStat};
      OFF_IE:    regRdata = {{(DW-NLAT){1'b0}}, ieMask};
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/bert_stat_irq.sv
module bert_stat_irq
  import bsl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  logic          errPulse,
  input  logic          oosIn,
  input  logic          reqPin,
  input  logic          portEn,
  input  logic          globalEn,
  input  logic [6:0]    regAddr,
  input  logic          regWr,
  input  logic [15:0]   regWdata,
  output logic [15:0]   regRdata,
  output logic          irq
);
  bslStb_t         stb;
  logic [DW-1:0]   ctrlWord, liveStat;
  logic [NLAT-1:0] ieMask, latStat;
  logic            reqRaw, updDone;

  bsl_ctrl ctrl (
    .clk(clk), .rstN(rstN), .reqPin(reqPin), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .stb(stb), .ctrlWord(ctrlWord), .ieMask(ieMask),
    .reqRaw(reqRaw), .updDone(updDone)
  );

  bsl_datapath #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bitEn(bitEn), .errPulse(errPulse),
    .oosIn(oosIn), .updDone(updDone), .portEn(portEn), .globalEn(globalEn),
    .ieMask(ieMask), .ctrlWord(ctrlWord), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .liveStat(liveStat), .latStat(latStat), .irq(irq)
  );
endmodule

// File: rtl/bsl_check.sv
module bsl_check (
  input logic        clk,
  input logic        rstN,
  input logic        errPulse,
  input logic        oosIn,
  input logic        portEn,
  input logic        globalEn,
  input logic        irq,
  input logic        reqRaw,
  input logic        capture,
  input logic [15:0] liveStat,
  input logic [3:0]  latStat
);
  a_r5_done_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    liveStat[3] |-> reqRaw);

  a_r5_done_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    $rose(liveStat[3]) |-> $past(capture, 2));

  a_r7_nz_rise_latches: assert property (@(posedge clk) disable iff (!rstN)
    $rose(liveStat[1]) |=> latStat[1]);

  a_r8_err_latches: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> latStat[2]);

  a_r8_oos_change_latches: assert property (@(posedge clk) disable iff (!rstN)
    (oosIn != $past(oosIn)) |=> latStat[0]);

  a_r10_irq_needs_enables: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (portEn && globalEn && (latStat != 4'b0)));
endmodule

bind bert_stat_irq bsl_check chk (
  .clk(clk), .rstN(rstN), .errPulse(errPulse), .oosIn(oosIn), .portEn(portEn),
  .globalEn(globalEn), .irq(irq), .reqRaw(reqRaw), .capture(stb.capture),
  .liveStat(liveStat), .latStat(latStat)
);

// File: tb/bert_stat_irq_test.sv
module bert_stat_irq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, errPulse = 1'b0, oosIn = 1'b0, reqPin = 1'b0;
  logic portEn = 1'b0, globalEn = 1'b0;
  logic [6:0] regAddr = 7'h0;
  logic regWr = 1'b0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] regRdata;
  logic irq;
  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bert_stat_irq uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .errPulse(errPulse), .oosIn(oosIn),
    .reqPin(reqPin), .portEn(portEn), .globalEn(globalEn), .regAddr(regAddr),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  // {ie[3:0], portEn, globalEn, expected irq} with latched word = 4'b0100
  localparam logic [6:0] IRQ_VEC [7] = '{
    {4'h4, 1'b1, 1'b1, 1'b1}, {4'h4, 1'b0, 1'b1, 1'b0}, {4'h4, 1'b1, 1'b0, 1'b0},
    {4'hB, 1'b1, 1'b1, 1'b0}, {4'hF, 1'b1, 1'b1, 1'b1}, {4'h0, 1'b1, 1'b1, 1'b0},
    {4'h4, 1'b0, 1'b0, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    tick();
    regWr = 1'b0; regWdata = 16'h0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [6:0] a, input logic [15:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    // R1 reset state
    rd("R1 ctrl", 7'h50, 16'h0);
    rd("R1 live", 7'h5C, 16'h0);
    rd("R1 latched", 7'h5E, 16'h0);
    rd("R1 ie", 7'h60, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // count 10 bits, 3 errors
    for (int i = 0; i < 10; i++) begin
      bitEn = 1'b1; errPulse = (i < 3);
      tick();
    end
    bitEn = 1'b0; errPulse = 1'b0;
    tick();

    // software request, edge k
    wr(7'h50, 16'h1);
    rd("R5 done not yet", 7'h5C, 16'h0);
    rd("R4 hold not yet", 7'h54, 16'h0);
    tick();
    rd("R4 bit hold", 7'h54, 16'd10);
    rd("R4 err hold", 7'h58, 16'd3);
    rd("R6 nz set, done low", 7'h5C, 16'h0002);
    tick();
    rd("R5 done high", 7'h5C, 16'h000A);
    tick();
    rd("R7 latched 3,2,1", 7'h5E, 16'h000E);

    // R3 switch to pin mode, pin low: done drops
    wr(7'h50, 16'h2);
    rd("R5 done low in pin mode", 7'h5C, 16'h0002);
    for (int i = 0; i < 4; i++) begin
      bitEn = 1'b1; tick();
    end
    bitEn = 1'b0;
    reqPin = 1'b1;
    tick();
    rd("R3 sync stage 1", 7'h54, 16'd10);
    tick();
    rd("R3 sync stage 2", 7'h54, 16'd10);
    tick();
    rd("R4 pin bit hold", 7'h54, 16'd4);
    rd("R4 pin err hold", 7'h58, 16'd0);
    rd("R6 nz clear", 7'h5C, 16'h0);
    tick();
    rd("R5 pin done", 7'h5C, 16'h0008);
    #5;
    reqPin = 1'b0;
    rd("R5 forced low", 7'h5C, 16'h0);
    tick(); tick(); tick();

    // R3 software bit ignored in pin mode
    wr(7'h50, 16'h3);
    bitEn = 1'b1; tick(); bitEn = 1'b0;
    tick(); tick(); tick();
    rd("R3 sw ignored", 7'h54, 16'd4);
    rd("R3 sw ignored live", 7'h5C, 16'h0);
    wr(7'h50, 16'h0);
    tick();

    // R9 clear behaviour
    wr(7'h5E, 16'h000F);
    rd("R9 clear all", 7'h5E, 16'h0);
    errPulse = 1'b1; tick(); errPulse = 1'b0;
    tick();
    wr(7'h5E, 16'h000B);
    rd("R9 zero bits kept", 7'h5E, 16'h0004);
    errPulse = 1'b1;
    wr(7'h5E, 16'h0004);
    errPulse = 1'b0;
    rd("R9 set wins", 7'h5E, 16'h0004);
    tick();
    wr(7'h5E, 16'h0004);
    rd("R9 cleared", 7'h5E, 16'h0);

    // R8 / R2 out-of-sync both edges
    oosIn = 1'b1;
    tick();
    rd("R2 live oos", 7'h5C, 16'h0001);
    rd("R8 oos rise", 7'h5E, 16'h0001);
    tick();
    wr(7'h5E, 16'h0001);
    rd("R9 oos clear", 7'h5E, 16'h0);
    oosIn = 1'b0;
    tick();
    rd("R8 oos fall", 7'h5E, 16'h0001);
    rd("R2 live oos low", 7'h5C, 16'h0);
    tick();
    wr(7'h5E, 16'h0001);

    // R10 interrupt gating table
    errPulse = 1'b1; tick(); errPulse = 1'b0;
    tick();
    rd("R8 err latched", 7'h5E, 16'h0004);
    foreach (IRQ_VEC[i]) begin
      wr(7'h60, {12'h0, IRQ_VEC[i][6:3]});
      portEn = IRQ_VEC[i][2];
      globalEn = IRQ_VEC[i][1];
      #1;
      chk($sformatf("R10 irq vec %0d", i), {15'b0, irq}, {15'b0, IRQ_VEC[i][0]});
    end
    rd("R10 ie readback", 7'h60, 16'h0004);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule